// File: doc/BRIEF.md
# Streaming Luma Quarter-Pel Interpolator

This block turns a stream of reference luma columns into every integer, half-pel and quarter-pel sample of a search area. Each accepted input is one column of eight vertically adjacent luma samples. The reference area is `W` columns wide and `STRIPES` stripes high, and each stripe is eight rows tall. Columns arrive left to right, one stripe after another. When the last column of a stripe has been accepted, the next column belongs to the next stripe. When the last stripe of an area has been accepted, the next column starts a new area.

A delay memory one stripe wide keeps six rows of each column of the stripe above. Combined with seven rows of the current column, this gives the thirteen samples that a vertical six-tap filter needs for eight output rows. As a result, the output window sits four rows higher than the input stripe. Pipelined horizontal, vertical and diagonal filter sets produce the half-pel samples. The quarter-pel samples are rounded averages of neighbouring integer and half-pel samples.

For each valid integer column the block presents 128 samples in a single cycle: sixteen positions times eight rows, split over two 8×8 blocks. The mapping of positions to block columns rotates with the column index. The pipeline advances only on accepted columns. A stream with idle cycles therefore gives the same results as a continuous one.

Top module: `luma_qpel_interp`

## Requirements
- R1: The pipeline advances only on a cycle with `inValid` high. `outValid` can be high only in the cycle after an accepted column. After a cycle with `inValid` low, `outBlk0` and `outBlk1` keep their values.
- R2: Output row r (0..7) of input stripe k corresponds to area row 8k−4+r. The integer position reproduces the reference sample at that row and at the emitted column.
- R3: A column c of stripe k is emitted only when k ≥ 1 and 2 ≤ c ≤ W−4. This gives (STRIPES−1)·(W−5) outputs per area, in stripe-major, column-ascending order. Stripe 0 of every area produces no output.
- R4: The output for a column is registered on the edge that accepts the sixth column after it in the stream. In a fresh stream the first `outValid` follows the acceptance of column number W+9, counted from 1.
- R5: The half-pel samples at positions b (right) and h (below) are clip((Σ tap·sample + 16) >> 5). Taps are (1,−5,20,20,−5,1) over columns c−2..c+3 or rows y−2..y+3. Results are clipped to 0..255.
- R6: The half-pel sample at position j (diagonal) is clip((Σ tap·V + 512) >> 10). V is the unrounded vertical six-tap sum at columns c−2..c+3.
- R7: Each quarter-pel sample is (a+b+1)>>1 of its two neighbours:
  - a = G, b; c = b, G(x+1)
  - d = G, h; e = b, h; f = b, j; g = b, h(x+1)
  - i = h, j; k = j, h(x+1)
  - n = G(y+1), h; p = h, b(y+1); q = j, b(y+1); r = h(x+1), b(y+1)
- R8: Position index p = 4·fy + fx, where fx and fy are quarter-sample offsets (G=0, a=1, b=2, h=8, j=10, r=15). Block B (0 or 1) column k carries position 8B + ((k + c) mod 8). Row r of block column k sits at bits [(8k+r)·8 +: 8].
- R9: While reset is asserted, `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Accepts `inCol` this cycle |
| inCol | input | ROWS*8 | Eight luma samples of one column, row 0 in the low byte |
| outValid | output | 1 | Output blocks hold a new column |
| outBlk0 | output | 64*ROWS | Positions 0..7 (fy 0 and 1), rotated |
| outBlk1 | output | 64*ROWS | Positions 8..15 (fy 2 and 3), rotated |

## Verification
The hardest case to reach from the ports is an idle cycle that falls while the six-column filter window straddles a stripe boundary. In that case the delay memory, the window and the valid tags must all freeze together. To reach it, the stimulus inserts idle cycles at two fixed strides. These drift across every column phase, including the wrap from column W−1 to column 0. A second area of alternating 0 and 255 rows and columns drives the six-tap sums far outside the sample range. This exercises clipping at both ends in the b, h and j paths.

// File: rtl/qpel_pkg.sv
package qpel_pkg;
  localparam int KEEP_ROWS = 6;   // rows of the stripe above kept per column
  localparam int PIPE_LAT  = 6;   // accepted columns between input and output

  typedef logic signed [21:0] acc_t;

  typedef struct packed {
    logic       adv;   // an input column is accepted
    logic       emit;  // the column leaving the pipe is inside the valid window
    logic [2:0] rot;   // rotation of position columns for that column
  } qpel_ctl_t;

  typedef struct packed {
    logic       v;
    logic [2:0] rot;
  } qpel_tag_t;

  localparam acc_t K5  = acc_t'(5);
  localparam acc_t K20 = acc_t'(20);

  function automatic acc_t ext8(input logic [7:0] x);
    return acc_t'({14'd0, x});
  endfunction

  // six-tap kernel; bias models the adder carry-in used for rounding
  function automatic acc_t tap6(input acc_t s0, input acc_t s1, input acc_t s2,
                                input acc_t s3, input acc_t s4, input acc_t s5,
                                input acc_t bias);
    return s0 + s5 - K5 * (s1 + s4) + K20 * (s2 + s3) + bias;
  endfunction

  function automatic logic [7:0] clipSh(input acc_t v, input int sh);
    acc_t t;
    t = v >>> sh;
    if (t < 0) return 8'd0;
    if (t > 255) return 8'd255;
    return t[7:0];
  endfunction

  function automatic logic [7:0] avg2(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + 9'd1;
    return s[8:1];
  endfunction
endpackage

// File: rtl/qpel_ctrl.sv
module qpel_ctrl
  import qpel_pkg::*;
#(
  parameter int W       = 40,
  parameter int STRIPES = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output qpel_ctl_t            ctl,
  output logic [$clog2(W)-1:0] slot
);
  localparam int CW = $clog2(W);
  localparam int SW = $clog2(STRIPES + 1);

  logic [CW-1:0] colCnt;
  logic [SW-1:0] stripeCnt;
  qpel_tag_t     tagIn;
  qpel_tag_t     tagPipe [PIPE_LAT];

  always_comb begin
    tagIn.v   = (stripeCnt != '0) && (colCnt >= CW'(2)) && (colCnt <= CW'(W - 4));
    tagIn.rot = 3'(colCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt    <= '0;
      stripeCnt <= '0;
      for (int i = 0; i < PIPE_LAT; i++) tagPipe[i] <= '0;
    end else if (inValid) begin
      if (colCnt == CW'(W - 1)) begin
        colCnt    <= '0;
        stripeCnt <= (stripeCnt == SW'(STRIPES - 1)) ? '0 : stripeCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
      tagPipe[0] <= tagIn;
      for (int i = 1; i < PIPE_LAT; i++) tagPipe[i] <= tagPipe[i-1];
    end
  end

  assign slot     = colCnt;
  assign ctl.adv  = inValid;
  assign ctl.emit = tagPipe[PIPE_LAT-1].v;
  assign ctl.rot  = tagPipe[PIPE_LAT-1].rot;
endmodule

// File: rtl/qpel_datapath.sv
module qpel_datapath
  import qpel_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int W    = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qpel_ctl_t            ctl,
  input  logic [$clog2(W)-1:0] slot,
  input  logic [ROWS*8-1:0]    inCol,
  output logic                 outValid,
  output logic [64*ROWS-1:0]   outBlk0,
  output logic [64*ROWS-1:0]   outBlk1
);
  localparam int SPAN  = ROWS + 5;
  localparam int GROWS = ROWS + 1;
  localparam int NPOS  = 16;
  localparam acc_t RND = acc_t'(16);

  // delay memory: one entry per column of the stripe above
  logic [KEEP_ROWS*8-1:0] dly [W];
  logic [SPAN*8-1:0]      span;

  always_ff @(posedge clk) begin
    if (ctl.adv) dly[slot] <= inCol[ROWS*8-1 -: KEEP_ROWS*8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) span <= '0;
    else if (ctl.adv) span <= {inCol[(ROWS-1)*8-1:0], dly[slot]};
  end

  // vertical filter cores, rounding bias folded in (carried on into j)
  acc_t       vNew [ROWS];
  logic [7:0] gNew [GROWS];
  for (genvar r = 0; r < ROWS; r++) begin : g_vert
    assign vNew[r] = tap6(ext8(span[r*8 +: 8]), ext8(span[(r+1)*8 +: 8]),
                          ext8(span[(r+2)*8 +: 8]), ext8(span[(r+3)*8 +: 8]),
                          ext8(span[(r+4)*8 +: 8]), ext8(span[(r+5)*8 +: 8]), RND);
  end
  for (genvar r = 0; r < GROWS; r++) begin : g_int
    assign gNew[r] = span[(r+2)*8 +: 8];
  end

  // six-column window: slot 2 is the emitted column
  logic [7:0] gWin [6][GROWS];
  acc_t       vWin [6][ROWS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 6; s++) begin
        for (int r = 0; r < GROWS; r++) gWin[s][r] <= '0;
        for (int r = 0; r < ROWS; r++)  vWin[s][r] <= '0;
      end
    end else if (ctl.adv) begin
      for (int s = 0; s < 5; s++) begin
        gWin[s] <= gWin[s+1];
        vWin[s] <= vWin[s+1];
      end
      gWin[5] <= gNew;
      vWin[5] <= vNew;
    end
  end

  // horizontal (b), diagonal (j) and vertical (h) half-pel sets
  logic [7:0] bMid [GROWS];
  logic [7:0] jMid [ROWS];
  logic [7:0] hMid0 [ROWS];
  logic [7:0] hMid1 [ROWS];
  for (genvar r = 0; r < GROWS; r++) begin : g_horz
    assign bMid[r] = clipSh(tap6(ext8(gWin[0][r]), ext8(gWin[1][r]), ext8(gWin[2][r]),
                                 ext8(gWin[3][r]), ext8(gWin[4][r]), ext8(gWin[5][r]), RND), 5);
  end
  for (genvar r = 0; r < ROWS; r++) begin : g_diag
    assign jMid[r]  = clipSh(tap6(vWin[0][r], vWin[1][r], vWin[2][r],
                                  vWin[3][r], vWin[4][r], vWin[5][r], '0), 10);
    assign hMid0[r] = clipSh(vWin[2][r], 5);
    assign hMid1[r] = clipSh(vWin[3][r], 5);
  end

  logic [7:0] gC0 [GROWS];
  logic [7:0] gC1 [GROWS];
  logic [7:0] bC  [GROWS];
  logic [7:0] hC0 [ROWS];
  logic [7:0] hC1 [ROWS];
  logic [7:0] jC  [ROWS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < GROWS; r++) begin
        gC0[r] <= '0; gC1[r] <= '0; bC[r] <= '0;
      end
      for (int r = 0; r < ROWS; r++) begin
        hC0[r] <= '0; hC1[r] <= '0; jC[r] <= '0;
      end
    end else if (ctl.adv) begin
      gC0 <= gWin[2];
      gC1 <= gWin[3];
      bC  <= bMid;
      hC0 <= hMid0;
      hC1 <= hMid1;
      jC  <= jMid;
    end
  end

  // quarter-pel averages and the sixteen positions
  logic [7:0] pos [NPOS][ROWS];
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      pos[0][r]  = gC0[r];
      pos[1][r]  = avg2(gC0[r], bC[r]);
      pos[2][r]  = bC[r];
      pos[3][r]  = avg2(bC[r], gC1[r]);
      pos[4][r]  = avg2(gC0[r], hC0[r]);
      pos[5][r]  = avg2(bC[r], hC0[r]);
      pos[6][r]  = avg2(bC[r], jC[r]);
      pos[7][r]  = avg2(bC[r], hC1[r]);
      pos[8][r]  = hC0[r];
      pos[9][r]  = avg2(hC0[r], jC[r]);
      pos[10][r] = jC[r];
      pos[11][r] = avg2(jC[r], hC1[r]);
      pos[12][r] = avg2(gC0[r+1], hC0[r]);
      pos[13][r] = avg2(hC0[r], bC[r+1]);
      pos[14][r] = avg2(jC[r], bC[r+1]);
      pos[15][r] = avg2(hC1[r], bC[r+1]);
    end
  end

  logic [64*ROWS-1:0] rotBlk0, rotBlk1;
  always_comb begin
    for (int k = 0; k < 8; k++) begin
      for (int r = 0; r < ROWS; r++) begin
        rotBlk0[(k*ROWS+r)*8 +: 8] = pos[{1'b0, 3'(k) + ctl.rot}][r];
        rotBlk1[(k*ROWS+r)*8 +: 8] = pos[{1'b1, 3'(k) + ctl.rot}][r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outBlk0  <= '0;
      outBlk1  <= '0;
    end else if (ctl.adv) begin
      outValid <= ctl.emit;
      outBlk0  <= rotBlk0;
      outBlk1  <= rotBlk1;
    end else begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/luma_qpel_interp.sv
module luma_qpel_interp
  import qpel_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int W       = 40,
  parameter int STRIPES = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [ROWS*8-1:0]  inCol,
  output logic               outValid,
  output logic [64*ROWS-1:0] outBlk0,
  output logic [64*ROWS-1:0] outBlk1
);
  qpel_ctl_t            ctl;
  logic [$clog2(W)-1:0] slot;

  qpel_ctrl #(.W(W), .STRIPES(STRIPES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctl(ctl), .slot(slot)
  );

  qpel_datapath #(.ROWS(ROWS), .W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .slot(slot), .inCol(inCol),
    .outValid(outValid), .outBlk0(outBlk0), .outBlk1(outBlk1)
  );
endmodule

// File: rtl/luma_qpel_interp_chk.sv
module luma_qpel_interp_chk #(
  parameter int ROWS    = 8,
  parameter int W       = 40,
  parameter int STRIPES = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               outValid,
  input logic [64*ROWS-1:0] outBlk0,
  input logic [64*ROWS-1:0] outBlk1
);
  int   accCnt;
  int   emitted, eCol, eStripe;
  logic expVal;

  always_ff @(posedge clk) begin
    if (!rstN) accCnt <= 0;
    else if (inValid) accCnt <= accCnt + 1;
  end

  always_comb begin
    emitted = accCnt - 7;
    eCol    = (emitted >= 0) ? emitted % W : 0;
    eStripe = (emitted >= 0) ? (emitted / W) % STRIPES : 0;
    expVal  = (emitted >= 0) && (eStripe != 0) && (eCol >= 2) && (eCol <= W - 4);
  end

  // R1: a new output only follows an accepted column
  assert_emit_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R1: blocks hold through idle cycles
  assert_hold_on_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outBlk0) && $stable(outBlk1)));

  // R3: only columns inside the window of a non-first stripe are emitted
  assert_valid_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> expVal);

  // R4: every in-window column is emitted six accepted columns later
  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && expVal) |-> outValid);
endmodule

bind luma_qpel_interp luma_qpel_interp_chk #(.ROWS(ROWS), .W(W), .STRIPES(STRIPES)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outBlk0(outBlk0), .outBlk1(outBlk1)
);

// File: tb/luma_qpel_interp_bench.sv
module luma_qpel_interp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 8;
  localparam int W          = 40;
  localparam int STRIPES    = 5;
  localparam int AREAS      = 2;
  localparam int HGT        = STRIPES * ROWS;
  localparam int PER_STRIPE = W - 5;
  localparam int PER_AREA   = (STRIPES - 1) * PER_STRIPE;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic [ROWS*8-1:0]  inCol = '0;
  logic               outValid;
  logic [64*ROWS-1:0] outBlk0, outBlk1;
  logic [64*ROWS-1:0] prevBlk0, prevBlk1;

  int img [AREAS][HGT][W];
  int total = 0, bad = 0, evIdx = 0, accCnt = 0;
  bit firstSeen = 0, lastAdv = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  luma_qpel_interp #(.ROWS(ROWS), .W(W), .STRIPES(STRIPES)) u_luma_qpel_interp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCol(inCol),
    .outValid(outValid), .outBlk0(outBlk0), .outBlk1(outBlk1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clip8(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction
  function automatic int avg(input int a, input int b);
    return (a + b + 1) >>> 1;
  endfunction
  function automatic int vsum(input int a, input int y, input int x);
    return img[a][y-2][x] - 5*img[a][y-1][x] + 20*img[a][y][x]
         + 20*img[a][y+1][x] - 5*img[a][y+2][x] + img[a][y+3][x];
  endfunction
  function automatic int bRef(input int a, input int y, input int x);
    int s = img[a][y][x-2] - 5*img[a][y][x-1] + 20*img[a][y][x]
          + 20*img[a][y][x+1] - 5*img[a][y][x+2] + img[a][y][x+3];
    return clip8((s + 16) >>> 5);
  endfunction
  function automatic int hRef(input int a, input int y, input int x);
    return clip8((vsum(a, y, x) + 16) >>> 5);
  endfunction
  function automatic int jRef(input int a, input int y, input int x);
    int s = vsum(a,y,x-2) - 5*vsum(a,y,x-1) + 20*vsum(a,y,x)
          + 20*vsum(a,y,x+1) - 5*vsum(a,y,x+2) + vsum(a,y,x+3);
    return clip8((s + 512) >>> 10);
  endfunction

  function automatic int expPos(input int a, input int y, input int x, input int p);
    int g = img[a][y][x], g1 = img[a][y][x+1], gd = img[a][y+1][x];
    int b = bRef(a,y,x), bd = bRef(a,y+1,x);
    int h = hRef(a,y,x), h1 = hRef(a,y,x+1), j = jRef(a,y,x);
    case (p)
      0: return g;            1: return avg(g, b);
      2: return b;            3: return avg(b, g1);
      4: return avg(g, h);    5: return avg(b, h);
      6: return avg(b, j);    7: return avg(b, h1);
      8: return h;            9: return avg(h, j);
      10: return j;           11: return avg(j, h1);
      12: return avg(gd, h);  13: return avg(h, bd);
      14: return avg(j, bd);  default: return avg(h1, bd);
    endcase
  endfunction

  function automatic string reqOf(input int p);
    if (p == 0) return "R2 integer/R8 layout";
    if (p == 2 || p == 8) return "R5 half-pel b/h";
    if (p == 10) return "R6 diagonal j";
    return "R7 quarter-pel";
  endfunction

  always @(posedge clk) begin
    if (inValid) accCnt <= accCnt + 1;
    lastAdv <= inValid;
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        chk(lastAdv, "R1 output without accepted column", 0, 1);
        if (!firstSeen) begin
          firstSeen = 1;
          chk(accCnt == W + 9, "R4 first output latency", accCnt, W + 9);
        end
        if (evIdx < AREAS * PER_AREA) begin
          int a   = evIdx / PER_AREA;
          int rem = evIdx % PER_AREA;
          int k   = 1 + rem / PER_STRIPE;
          int c   = 2 + rem % PER_STRIPE;
          for (int bk = 0; bk < 2; bk++) begin
            for (int kk = 0; kk < 8; kk++) begin
              int p = 8*bk + ((kk + c) % 8);
              int badAct = -1, badExp = -1;
              for (int r = 0; r < ROWS; r++) begin
                int act = (bk == 0) ? int'(outBlk0[(kk*ROWS+r)*8 +: 8])
                                    : int'(outBlk1[(kk*ROWS+r)*8 +: 8]);
                int exp = expPos(a, 8*k - 4 + r, c, p);
                if (act != exp && badAct < 0) begin badAct = act; badExp = exp; end
              end
              chk(badAct < 0, reqOf(p), badAct, badExp);
            end
          end
        end else begin
          chk(0, "R3 extra output", evIdx, AREAS * PER_AREA);
        end
        evIdx++;
      end else if (!lastAdv) begin
        chk(outBlk0 == prevBlk0 && outBlk1 == prevBlk1, "R1 hold on idle", 0, 0);
      end
      prevBlk0 = outBlk0;
      prevBlk1 = outBlk1;
    end
  end

  initial begin
    int n = 0;
    for (int y = 0; y < HGT; y++)
      for (int x = 0; x < W; x++) begin
        img[0][y][x] = (y*97 + x*57 + ((y*x) % 31) * 7) % 256;
        if (y < 20)      img[1][y][x] = ((x + y) & 1) ? 255 : 0;
        else if (y < 30) img[1][y][x] = ((x >> 1) & 1) ? 255 : 0;
        else             img[1][y][x] = ((y >> 1) & 1) ? 255 : (x * 13) % 256;
      end
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R9 outValid low in reset", outValid, 0);
    rstN = 1'b1;
    for (int a = 0; a < AREAS; a++)
      for (int s = 0; s < STRIPES; s++)
        for (int c = 0; c < W; c++) begin
          @(negedge clk);
          if (n % 13 == 5 || n % 29 == 0) begin
            inValid = 1'b0;
            @(negedge clk);
          end
          for (int r = 0; r < ROWS; r++) inCol[r*8 +: 8] = 8'(img[a][8*s + r][c]);
          inValid = 1'b1;
          n++;
        end
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      inCol   = '0;
      inValid = 1'b1;
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    chk(evIdx == AREAS * PER_AREA, "R3 output count", evIdx, AREAS * PER_AREA);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", evIdx, AREAS * PER_AREA);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule